// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

A combinational execution unit for a 64-bit integer core. It implements the basic bit-manipulation group: counting leading zeros, trailing zeros and set bits; logic operations that invert the second operand; signed and unsigned minimum and maximum; byte and halfword extensions; rotates; byte reversal; and a byte-wise OR-combine. Decode supplies the operation select, both operands and a word-mode flag, and the result comes back in the same cycle. When decode has already resolved an immediate rotate amount, it places that amount on `opb`, so immediate and register rotates share one path.

Word mode selects the 32-bit forms for operations in 64-bit code. These are the counts, the rotates and the byte reversal. The counts look only at the low word. The rotate and reversal forms truncate their inputs to 32 bits and then sign-extend bit 31 of the result. A registered valid follows the input valid by one clock, so a pipeline can line up the result with the stage that follows.

Top module: `bitmanip_unit`

## Requirements
- R1: Operation 0 counts leading zeros: with word_mode 0 it gives 64 for a zero operand; with word_mode 1 it counts within opa[31:0] only and gives 32 when that word is zero.
- R2: Operation 1 counts trailing zeros and gives 64, or 32 in word mode (counting opa[31:0] only), when the counted bits are all zero.
- R3: Operation 2 counts set bits of opa, or only of opa[31:0] in word mode.
- R4: Operations 3, 4 and 5 give opa AND NOT opb, opa OR NOT opb and opa XNOR opb.
- R5: Operations 6, 7, 8 and 9 give signed minimum, unsigned minimum, signed maximum and unsigned maximum of opa and opb.
- R6: Operations 10 and 11 sign-extend opa from bit 7 and from bit 15; operation 12 zero-extends opa from bit 15.
- R7: Operations 13 and 14 rotate opa left and right by opb[5:0], ignoring the higher bits of opb.
- R8: In word mode, operations 13 and 14 rotate opa[31:0] by opb[4:0] within 32 bits and sign-extend bit 31 of that result to 64 bits.
- R9: Operation 15 reverses all eight bytes of opa; in word mode it reverses the four bytes of opa[31:0] and sign-extends the result.
- R10: Operation 16 sets each result byte to 8'hFF when the matching byte of opa is non-zero and to 8'h00 otherwise.
- R11: Any operation select above 16 gives a zero result and raises `illegal`; legal selects keep `illegal` low.
- R12: `out_valid` is cleared by reset and equals `in_valid` as it was on the previous rising clock edge.
- R13: word_mode has no effect on operations 3 through 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and select are valid |
| op_sel | input | 5 | Operation select |
| word_mode | input | 1 | Use 32-bit word forms |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand or rotate amount |
| result | output | 64 | Combinational result |
| illegal | output | 1 | Select does not name an operation |
| out_valid | output | 1 | in_valid delayed by one clock |

## Verification
The unit has almost no internal state, so a fault in the datapath appears on `result` in the same cycle as the stimulus. Boundary values show up most mistakes at once: a count that is off by one at a zero input, a rotate amount with a stray high bit, or a missing sign-extension in word mode. The one register shows up on `out_valid` one edge after a pulse, and a stuck value shows up on the next idle cycle.

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4:0]      op_sel,
  input  logic            word_mode,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] result,
  output logic            illegal,
  output logic            out_valid
);

  localparam int HALF = XLEN / 2;
  localparam int NBYTE = XLEN / 8;
  localparam int CW = $clog2(XLEN) + 1;
  localparam int SW = $clog2(XLEN);

  localparam logic [4:0] K_CLZ  = 5'd0;
  localparam logic [4:0] K_CTZ  = 5'd1;
  localparam logic [4:0] K_CPOP = 5'd2;
  localparam logic [4:0] K_ANDN = 5'd3;
  localparam logic [4:0] K_ORN  = 5'd4;
  localparam logic [4:0] K_XNOR = 5'd5;
  localparam logic [4:0] K_MIN  = 5'd6;
  localparam logic [4:0] K_MINU = 5'd7;
  localparam logic [4:0] K_MAX  = 5'd8;
  localparam logic [4:0] K_MAXU = 5'd9;
  localparam logic [4:0] K_SXB  = 5'd10;
  localparam logic [4:0] K_SXH  = 5'd11;
  localparam logic [4:0] K_ZXH  = 5'd12;
  localparam logic [4:0] K_ROL  = 5'd13;
  localparam logic [4:0] K_ROR  = 5'd14;
  localparam logic [4:0] K_REV  = 5'd15;
  localparam logic [4:0] K_ORC  = 5'd16;

  logic [XLEN-1:0] lead_src, trail_src, pop_src;
  logic [CW-1:0]   lead_n, trail_n, pop_n;

  // a sentinel one below or above the word bounds the count at HALF
  assign lead_src  = word_mode ? {opa[HALF-1:0], {HALF{1'b1}}} : opa;
  assign trail_src = word_mode ? {{(HALF-1){1'b0}}, 1'b1, opa[HALF-1:0]} : opa;
  assign pop_src   = word_mode ? {{HALF{1'b0}}, opa[HALF-1:0]} : opa;

  always_comb begin
    lead_n = CW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (lead_src[i]) lead_n = CW'(XLEN - 1 - i);
  end

  always_comb begin
    trail_n = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--)
      if (trail_src[i]) trail_n = CW'(i);
  end

  always_comb begin
    pop_n = '0;
    for (int i = 0; i < XLEN; i++)
      pop_n = pop_n + CW'(pop_src[i]);
  end

  logic [SW-1:0]     amt_d;
  logic [SW-2:0]     amt_w;
  logic [2*XLEN-1:0] rot_d;
  logic [XLEN-1:0]   rot_w2;
  logic [XLEN-1:0]   rot_res;

  assign amt_d  = (op_sel == K_ROL) ? SW'(-opb[SW-1:0]) : opb[SW-1:0];
  assign amt_w  = (op_sel == K_ROL) ? (SW-1)'(-opb[SW-2:0]) : opb[SW-2:0];
  assign rot_d  = {opa, opa} >> amt_d;
  assign rot_w2 = {opa[HALF-1:0], opa[HALF-1:0]} >> amt_w;
  assign rot_res = word_mode ? {{HALF{rot_w2[HALF-1]}}, rot_w2[HALF-1:0]}
                             : rot_d[XLEN-1:0];

  logic [XLEN-1:0] rev_d, rev_w, orc;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign rev_d[8*g +: 8] = opa[8*(NBYTE-1-g) +: 8];
    assign orc[8*g +: 8]   = {8{|opa[8*g +: 8]}};
  end

  for (genvar g = 0; g < NBYTE/2; g++) begin : g_wbyte
    assign rev_w[8*g +: 8] = opa[8*(NBYTE/2-1-g) +: 8];
  end
  assign rev_w[XLEN-1:HALF] = {HALF{opa[7]}};

  logic s_lt, u_lt;
  assign s_lt = $signed(opa) < $signed(opb);
  assign u_lt = opa < opb;

  always_comb begin
    illegal = 1'b0;
    unique case (op_sel)
      K_CLZ:  result = XLEN'(lead_n);
      K_CTZ:  result = XLEN'(trail_n);
      K_CPOP: result = XLEN'(pop_n);
      K_ANDN: result = opa & ~opb;
      K_ORN:  result = opa | ~opb;
      K_XNOR: result = ~(opa ^ opb);
      K_MIN:  result = s_lt ? opa : opb;
      K_MINU: result = u_lt ? opa : opb;
      K_MAX:  result = s_lt ? opb : opa;
      K_MAXU: result = u_lt ? opb : opa;
      K_SXB:  result = {{(XLEN-8){opa[7]}}, opa[7:0]};
      K_SXH:  result = {{(XLEN-16){opa[15]}}, opa[15:0]};
      K_ZXH:  result = {{(XLEN-16){1'b0}}, opa[15:0]};
      K_ROL, K_ROR: result = rot_res;
      K_REV:  result = word_mode ? rev_w : rev_d;
      K_ORC:  result = orc;
      default: begin
        result  = '0;
        illegal = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;

endmodule

module bitmanip_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  op_sel,
  input logic        word_mode,
  input logic [63:0] opa,
  input logic [63:0] result,
  input logic        illegal,
  input logic        out_valid
);

  a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == 64'd0 && op_sel > 5'd16));

  a_r11_legal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel <= 5'd16) |-> !illegal);

  a_r12_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r12_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r1_clz_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd0) |-> (result <= (word_mode ? 64'd32 : 64'd64)));

  a_r3_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd2 && word_mode) |-> (result <= 64'd32));

  a_r8_word_rot_sext: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == 5'd13 || op_sel == 5'd14) && word_mode)
      |-> (result[63:32] == {32{result[31]}}));

  a_r10_orc_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 5'd16) |-> ((result[7:0] == 8'h00) == (opa[7:0] == 8'h00)));

endmodule

bind bitmanip_unit bitmanip_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .word_mode(word_mode), .opa(opa), .result(result), .illegal(illegal),
  .out_valid(out_valid)
);

// File: tb/test_bitmanip_unit.sv
module test_bitmanip_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, word_mode = 1'b0;
  logic [4:0] op_sel = '0;
  logic [63:0] opa = '0, opb = '0, result;
  logic illegal, out_valid;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmanip_unit i_bitmanip_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .word_mode(word_mode), .opa(opa), .opb(opb), .result(result),
    .illegal(illegal), .out_valid(out_valid)
  );

  localparam logic [4:0] V_OP [NV] = '{
    0, 0, 0, 0,          // R1
    1, 1, 1,             // R2
    2, 2,                // R3
    3, 4, 5,             // R4
    6, 7, 8, 9,          // R5
    10, 11, 12,          // R6
    13, 14, 14,          // R7
    13, 14,              // R8
    15, 15,              // R9
    16,                  // R10
    17,                  // R11
    3, 8                 // R13
  };
  localparam logic V_WM [NV] = '{
    0,0,1,1, 0,0,1, 0,1, 0,0,0, 0,0,0,0, 0,0,0, 0,0,0, 1,1, 0,1, 0, 0, 1,1
  };
  localparam logic [63:0] V_A [NV] = '{
    64'h0, 64'h1, 64'hFFFFFFFF_00000000, 64'h00000000_00010000,
    64'h0, 64'h80000000_00000000, 64'h00000001_00000000,
    64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_0000000F,
    64'hF0F0F0F0_F0F0F0F0, 64'h0, 64'h12345678_90ABCDEF,
    64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF,
    64'h00000000_00000080, 64'h12345678_9ABC7FFF, 64'hFFFFFFFF_FFFF8001,
    64'h80000000_00000001, 64'h1, 64'h12345678_90ABCDEF,
    64'hFFFFFFFF_80000000, 64'h1,
    64'h01020304_05060708, 64'hAAAAAAAA_112233F4,
    64'h00010080_0000FF00,
    64'hDEADBEEF_DEADBEEF,
    64'hF0F0F0F0_F0F0F0F0, 64'h1
  };
  localparam logic [63:0] V_B [NV] = '{
    0,0,0,0, 0,0,0, 0,0,
    64'hFF00FF00_FF00FF00, 64'hFFFFFFFF_00000000, 64'h12345678_90ABCDEF,
    1,1,1,1, 0,0,0,
    64'h1, 64'h41, 64'h0,
    64'h21, 64'h1,
    0,0, 0, 0,
    64'hFF00FF00_FF00FF00, 64'hFFFFFFFF_00000000
  };
  localparam logic [63:0] V_E [NV] = '{
    64'd64, 64'd63, 64'd32, 64'd15,
    64'd64, 64'd63, 64'd32,
    64'd64, 64'd4,
    64'h00F000F0_00F000F0, 64'h00000000_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF,
    64'hFFFFFFFF_FFFFFFFF, 64'h1, 64'h1, 64'hFFFFFFFF_FFFFFFFF,
    64'hFFFFFFFF_FFFFFF80, 64'h7FFF, 64'h8001,
    64'h3, 64'h80000000_00000000, 64'h12345678_90ABCDEF,
    64'h1, 64'hFFFFFFFF_80000000,
    64'h08070605_04030201, 64'hFFFFFFFF_F4332211,
    64'h00FF00FF_0000FF00,
    64'h0,
    64'h00F000F0_00F000F0, 64'h1
  };
  localparam int V_R [NV] = '{
    1,1,1,1, 2,2,2, 3,3, 4,4,4, 5,5,5,5, 6,6,6, 7,7,7, 8,8, 9,9, 10, 11, 13,13
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    check("R12 reset", 64'(out_valid), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op_sel = V_OP[i];
      word_mode = V_WM[i];
      opa = V_A[i];
      opb = V_B[i];
      #1;
      check($sformatf("R%0d vec%0d", V_R[i], i), result, V_E[i]);
      check($sformatf("R11 flag vec%0d", i), 64'(illegal), 64'(V_OP[i] > 5'd16));
    end

    // R11: top of select range
    op_sel = 5'd31; opa = '1; #1;
    check("R11 op31 result", result, 64'd0);
    check("R11 op31 flag", 64'(illegal), 64'd1);

    // R12: valid pulse
    @(negedge clk) in_valid = 1'b1;
    check("R12 before edge", 64'(out_valid), 64'd0);
    @(negedge clk) in_valid = 1'b0;
    check("R12 after edge", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R12 drop", 64'(out_valid), 64'd0);

    // R12: reset clears a held valid
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R12 async clear", 64'(out_valid), 64'd0);
    @(negedge clk) rst_n = 1'b1; in_valid = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule